// File: doc/BRIEF.md
# Serial-Bus Byte Memory Slave

This block is the slave side of a four-wire serial memory link in clock mode 0, sitting in front of a small byte-addressed nonvolatile store. A host lowers an active-low select, toggles a serial clock and shifts in one command byte. Some commands take a two-byte address and data bytes after it. The block answers on a single serial output line. All four wire inputs are brought into a faster system clock domain, and their edges are detected there, so the whole design runs on that one clock.

Six commands are supported: arm writes, disarm writes, read status, write status, stream-read the array and page-write the array. A modifying command takes effect only when the select line rises at a byte boundary. It then opens a busy window of a fixed number of system clocks. The write is applied to storage at the end of that window, and the arm bit drops at the same time. While the window is open, the block answers only the status read.

Top module: `spiee_top`

## Requirements
- R1: Serial input is sampled on rising serial-clock edges while select is low, most significant bit first. A command byte counts only when its upper nibble is 0000, and bit 3 is ignored. The lower three bits encode the command: 110 arm, 100 disarm, 101 status read, 001 status write, 011 array read, 010 array write. Any other byte, for example 0x16 or 0x86, is ignored.
- R2: The serial output changes only after a falling serial-clock edge or a select edge, most significant bit first. It is 0 while the block is not transmitting.
- R3: After reset the status reads 0x00: not busy, writes disarmed, protection fields clear.
- R4: Arm (0x06 or 0x0E) sets status bit 1 when select rises after the command byte. Disarm (0x04) clears it.
- R5: Status byte layout: bit 0 busy, bit 1 arm, bits 3:2 protect field, bit 7 protect-enable, bits 6:4 read 0. After the status-read byte, the status is sent again for every further byte clocked.
- R6: A status write uses the first data byte. It changes only bits 7 and 3:2, starts a busy window, and clears bit 1 when the window ends.
- R7: Array read takes a 16-bit address. Address bits above the array size are ignored. Bytes stream from consecutive addresses, wrapping from the last byte to address 0.
- R8: Array write buffers data bytes within the addressed 32-byte aligned page, with the offset wrapping inside the page. A later byte for the same offset replaces an earlier one. All buffered bytes are stored when the busy window ends.
- R9: If select rises in the middle of a byte, the command is discarded: the arm bit is unchanged and nothing is written.
- R10: A status or array write keeps bit 0 at 1 for BUSY_CYCLES system clocks after select rises. Bit 0 and bit 1 clear on the same clock.
- R11: While busy, every command except status read is ignored. An array read then returns 0x00 on the output line.
- R12: A status or array write without the arm bit set, or with no complete data byte, is ignored: no busy window and no storage change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chipSelN | input | 1 | Active-low select from the host |
| serClk | input | 1 | Serial clock from the host, idle low |
| serDataIn | input | 1 | Serial data from the host |
| serDataOut | output | 1 | Serial data to the host |

## Verification
Two events can land on the same system clock. One is the end of the busy window, which clears bits 0 and 1 and writes storage. The other is the byte-boundary reload of the status shift register during a long status-read stream. The bench provokes this by starting a status-read stream right after each write. It keeps clocking status bytes until busy drops. Every byte must read either both bits set or both clear, never a mix. The written data are then read back to confirm the store happened.

// File: rtl/spiee_pkg.sv
package spiee_pkg;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_ARM, CMD_DISARM, CMD_STAT_RD, CMD_STAT_WR, CMD_ARR_RD, CMD_ARR_WR
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_AHI, ST_ALO, ST_DATA, ST_SKIP
  } phase_e;

  // Strobes sent from control to datapath
  typedef struct packed {
    logic sampleBit;
    logic capAddrHi;
    logic capAddrLo;
    logic loadStatusTx;
    logic loadMemTx;
    logic pageClear;
    logic pageWrite;
    logic capStatus;
    logic commitArray;
    logic commitStatus;
    logic txShift;
    logic txStop;
  } dpStrobe_t;

  function automatic cmd_e decodeOp(input logic [7:0] b);
    cmd_e c;
    c = CMD_NONE;
    if (b[7:4] == 4'h0) begin
      case (b[2:0])
        3'b110:  c = CMD_ARM;
        3'b100:  c = CMD_DISARM;
        3'b101:  c = CMD_STAT_RD;
        3'b001:  c = CMD_STAT_WR;
        3'b011:  c = CMD_ARR_RD;
        3'b010:  c = CMD_ARR_WR;
        default: c = CMD_NONE;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/spiee_sync.sv
module spiee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csNIn,
  input  logic sckIn,
  input  logic sdIn,
  output logic csFall,
  output logic csRise,
  output logic sckRise,
  output logic sckFall,
  output logic sdSync
);
  logic [STAGES-1:0] csPipe, sckPipe, sdPipe;
  logic csPrev, sckPrev;
  logic csNow, sckNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe  <= '1;
      sckPipe <= '0;
      sdPipe  <= '0;
      csPrev  <= 1'b1;
      sckPrev <= 1'b0;
    end else begin
      csPipe  <= {csPipe[STAGES-2:0], csNIn};
      sckPipe <= {sckPipe[STAGES-2:0], sckIn};
      sdPipe  <= {sdPipe[STAGES-2:0], sdIn};
      csPrev  <= csPipe[STAGES-1];
      sckPrev <= sckPipe[STAGES-1];
    end
  end

  assign csNow   = csPipe[STAGES-1];
  assign sckNow  = sckPipe[STAGES-1];
  assign sdSync  = sdPipe[STAGES-1];
  assign csFall  = csPrev & ~csNow;
  assign csRise  = ~csPrev & csNow;
  assign sckRise = ~sckPrev & sckNow & ~csNow;
  assign sckFall = sckPrev & ~sckNow & ~csNow;

endmodule

// File: rtl/spiee_ctrl.sv
module spiee_ctrl
  import spiee_pkg::*;
#(
  parameter int BUSY_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csFall,
  input  logic       csRise,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic [7:0] rxByte,
  output dpStrobe_t  stb,
  output logic       wel,
  output logic       busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  phase_e      phase;
  cmd_e        cmd;
  cmd_e        decoded;
  logic [2:0]  bitCnt;
  logic        gotData;
  logic [CW-1:0] busyCnt;
  logic        pendArray;
  logic        byteDone;
  logic        opcOk;
  logic        busyEnd;

  assign byteDone = sckRise && (bitCnt == 3'd7) && (phase != ST_IDLE);
  assign decoded  = decodeOp(rxByte);
  assign opcOk    = (decoded != CMD_NONE) && (!busy || decoded == CMD_STAT_RD);
  assign busyEnd  = busy && (busyCnt == '0);

  always_comb begin
    stb = '0;
    stb.sampleBit    = sckRise;
    stb.txShift      = sckFall;
    stb.txStop       = csRise | csFall;
    stb.commitArray  = busyEnd && pendArray;
    stb.commitStatus = busyEnd && !pendArray;
    if (byteDone) begin
      case (phase)
        ST_OPC: begin
          stb.loadStatusTx = opcOk && (decoded == CMD_STAT_RD);
          stb.pageClear    = opcOk && (decoded == CMD_ARR_WR);
        end
        ST_AHI: stb.capAddrHi = 1'b1;
        ST_ALO: begin
          stb.capAddrLo = 1'b1;
          stb.loadMemTx = (cmd == CMD_ARR_RD);
        end
        ST_DATA: begin
          case (cmd)
            CMD_STAT_RD: stb.loadStatusTx = 1'b1;
            CMD_ARR_RD:  stb.loadMemTx    = 1'b1;
            CMD_ARR_WR:  stb.pageWrite    = 1'b1;
            CMD_STAT_WR: stb.capStatus    = !gotData;
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= ST_IDLE;
      cmd       <= CMD_NONE;
      bitCnt    <= '0;
      gotData   <= 1'b0;
      wel       <= 1'b0;
      busy      <= 1'b0;
      busyCnt   <= '0;
      pendArray <= 1'b0;
    end else begin
      if (csFall) begin
        phase   <= ST_OPC;
        cmd     <= CMD_NONE;
        bitCnt  <= '0;
        gotData <= 1'b0;
      end else if (csRise) begin
        if (phase != ST_IDLE && bitCnt == 3'd0 && !busy) begin
          case (cmd)
            CMD_ARM:    wel <= 1'b1;
            CMD_DISARM: wel <= 1'b0;
            CMD_STAT_WR, CMD_ARR_WR: begin
              if (wel && gotData) begin
                busy      <= 1'b1;
                busyCnt   <= CW'(BUSY_CYCLES - 1);
                pendArray <= (cmd == CMD_ARR_WR);
              end
            end
            default: ;
          endcase
        end
        phase <= ST_IDLE;
      end else if (sckRise && phase != ST_IDLE) begin
        bitCnt <= bitCnt + 3'd1;
        if (byteDone) begin
          case (phase)
            ST_OPC: begin
              if (opcOk) begin
                cmd <= decoded;
                if (decoded == CMD_ARR_RD || decoded == CMD_ARR_WR) phase <= ST_AHI;
                else phase <= ST_DATA;
              end else begin
                phase <= ST_SKIP;
              end
            end
            ST_AHI:  phase <= ST_ALO;
            ST_ALO:  phase <= ST_DATA;
            ST_DATA: gotData <= 1'b1;
            default: ;
          endcase
        end
      end

      if (busy) begin
        if (busyCnt == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else begin
          busyCnt <= busyCnt - 1'b1;
        end
      end
    end
  end

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(csRise));

  // R9
  busy_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(bitCnt == 3'd0));

  // R11
  arm_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wel) |-> $past(!busy));

  // R10
  arm_clear_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> !wel);

  // R12
  busy_needs_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wel));

endmodule

// File: rtl/spiee_data.sv
module spiee_data
  import spiee_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic       sdSync,
  input  logic       wel,
  input  logic       busy,
  output logic [7:0] rxByte,
  output logic       so
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  logic [6:0]        shReg;
  logic [7:0]        addrHi;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] combAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [7:0]        mem [DEPTH];
  logic [7:0]        pageBuf [PAGE];
  logic [PAGE-1:0]   pageVld;
  logic [7:0]        stageStatus;
  logic              protEn;
  logic [1:0]        protField;
  logic [7:0]        status;
  logic [7:0]        tx;
  logic              txEn;

  assign rxByte   = {shReg, sdSync};
  assign combAddr = ADDR_W'({addrHi, rxByte});
  assign rdAddr   = stb.capAddrLo ? combAddr : ptr;
  assign status   = {protEn, 3'b000, protField, wel, busy};

  // Input shift and address tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      addrHi <= '0;
      ptr    <= '0;
    end else begin
      if (stb.sampleBit) shReg <= rxByte[6:0];
      if (stb.capAddrHi) addrHi <= rxByte;
      if (stb.capAddrLo) begin
        ptr <= stb.loadMemTx ? combAddr + 1'b1 : combAddr;
      end else if (stb.loadMemTx) begin
        ptr <= ptr + 1'b1;
      end else if (stb.pageWrite) begin
        ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
      end
    end
  end

  // Page buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageVld <= '0;
    end else if (stb.pageClear) begin
      pageVld <= '0;
    end else if (stb.pageWrite) begin
      pageVld[ptr[PAGE_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (stb.pageWrite) pageBuf[ptr[PAGE_W-1:0]] <= rxByte;
  end

  // Storage array commit
  always_ff @(posedge clk) begin
    if (stb.commitArray) begin
      for (int i = 0; i < PAGE; i++) begin
        if (pageVld[i]) mem[{ptr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
      end
    end
  end

  // Status protection fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageStatus <= '0;
      protEn      <= 1'b0;
      protField   <= '0;
    end else begin
      if (stb.capStatus) stageStatus <= rxByte;
      if (stb.commitStatus) begin
        protEn    <= stageStatus[7];
        protField <= stageStatus[3:2];
      end
    end
  end

  // Output shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tx   <= '0;
      txEn <= 1'b0;
      so   <= 1'b0;
    end else if (stb.txStop) begin
      txEn <= 1'b0;
      so   <= 1'b0;
    end else if (stb.loadStatusTx) begin
      tx   <= status;
      txEn <= 1'b1;
    end else if (stb.loadMemTx) begin
      tx   <= mem[rdAddr];
      txEn <= 1'b1;
    end else if (stb.txShift && txEn) begin
      so <= tx[7];
      tx <= {tx[6:0], 1'b0};
    end
  end

  // R2
  so_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (so != $past(so)) |-> $past(stb.txShift || stb.txStop));

  // R6
  prot_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({protEn, protField}) |-> $past(stb.commitStatus));

  // R8
  page_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.pageWrite);

endmodule

// File: rtl/spiee_top.sv
module spiee_top
  import spiee_pkg::*;
#(
  parameter int ARRAY_BYTES = 2048,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic chipSelN,
  input  logic serClk,
  input  logic serDataIn,
  output logic serDataOut
);
  localparam int ADDR_W = $clog2(ARRAY_BYTES);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic csFall, csRise, sckRise, sckFall, sdSync;
  logic wel, busy;
  logic [7:0] rxByte;
  dpStrobe_t stb;

  spiee_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .csNIn(chipSelN), .sckIn(serClk), .sdIn(serDataIn),
    .csFall(csFall), .csRise(csRise), .sckRise(sckRise), .sckFall(sckFall),
    .sdSync(sdSync)
  );

  spiee_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) uCtrl (
    .clk(clk), .rstN(rstN), .csFall(csFall), .csRise(csRise),
    .sckRise(sckRise), .sckFall(sckFall), .rxByte(rxByte),
    .stb(stb), .wel(wel), .busy(busy)
  );

  spiee_data #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .sdSync(sdSync), .wel(wel), .busy(busy),
    .rxByte(rxByte), .so(serDataOut)
  );

endmodule

// File: tb/tb_spiee_top.sv
module tb_spiee_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipSelN = 1'b1;
  logic serClk = 1'b0;
  logic serDataIn = 1'b0;
  logic serDataOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] rd;

  spiee_top dut (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .serClk(serClk),
    .serDataIn(serDataIn), .serDataOut(serDataOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] out, output logic [7:0] in);
    for (int b = 7; b >= 0; b--) begin
      serDataIn = out[b];
      waitCyc(HALF);
      in[b] = serDataOut;
      serClk = 1'b1;
      waitCyc(HALF);
      serClk = 1'b0;
    end
  endtask

  task automatic sendBits(input logic [7:0] out, input int n);
    for (int b = 7; b > 7 - n; b--) begin
      serDataIn = out[b];
      waitCyc(HALF);
      serClk = 1'b1;
      waitCyc(HALF);
      serClk = 1'b0;
    end
  endtask

  task automatic selLow();
    chipSelN = 1'b0;
    waitCyc(HALF);
  endtask

  task automatic selHigh();
    waitCyc(HALF);
    chipSelN = 1'b1;
    waitCyc(HALF);
  endtask

  task automatic oneByte(input logic [7:0] op);
    logic [7:0] d;
    selLow(); xfer(op, d); selHigh();
  endtask

  task automatic readStatus(output logic [7:0] st);
    logic [7:0] d;
    selLow(); xfer(8'h05, d); xfer(8'h00, st); selHigh();
  endtask

  task automatic sendAddr(input logic [7:0] op, input logic [15:0] a);
    logic [7:0] d;
    xfer(op, d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  task automatic readByteAt(input logic [15:0] a, output logic [7:0] v);
    selLow(); sendAddr(8'h03, a); xfer(8'h00, v); selHigh();
  endtask

  // Stream status until busy drops; bits 1:0 must be 11 or 00 in every byte
  task automatic pollReady(input string req, input bit needBusy);
    logic [7:0] d, st;
    bit sawBusy = 0;
    bit done = 0;
    selLow();
    xfer(8'h05, d);
    for (int n = 0; n < 16 && !done; n++) begin
      xfer(8'h00, st);
      if (st[0]) begin
        sawBusy = 1;
        check({req, " R10 arm held while busy"}, {6'd0, st[1:0]}, 8'h03);
      end else begin
        done = 1;
        check({req, " R10 arm cleared with busy"}, {6'd0, st[1:0]}, 8'h00);
      end
    end
    selHigh();
    check({req, " R10 busy ended"}, {7'd0, done}, 8'h01);
    if (needBusy) check({req, " R10 busy seen"}, {7'd0, sawBusy}, 8'h01);
  endtask

  task automatic testReset();
    check("R2 output idle after reset", {7'd0, serDataOut}, 8'h00);
    readStatus(rd);
    check("R3 reset status", rd, 8'h00);
  endtask

  task automatic testOpcodes();
    oneByte(8'h16); readStatus(rd);
    check("R1 upper nibble nonzero ignored", rd, 8'h00);
    oneByte(8'h0E); readStatus(rd);
    check("R1 R4 arm with bit3 set", rd, 8'h02);
    oneByte(8'h86); readStatus(rd);
    check("R1 invalid byte leaves arm", rd, 8'h02);
    oneByte(8'h04); readStatus(rd);
    check("R4 disarm", rd, 8'h00);
    check("R2 output idle with select high", {7'd0, serDataOut}, 8'h00);
  endtask

  task automatic testStatusRepeat();
    logic [7:0] d, s1, s2, s3;
    oneByte(8'h06);
    selLow(); xfer(8'h05, d); xfer(8'h00, s1); xfer(8'h00, s2); xfer(8'h00, s3); selHigh();
    check("R5 status repeat 1", s1, 8'h02);
    check("R5 status repeat 2", s2, 8'h02);
    check("R5 status repeat 3", s3, 8'h02);
    oneByte(8'h04);
  endtask

  task automatic testMidByte();
    selLow(); sendBits(8'h06, 4); selHigh();
    readStatus(rd);
    check("R9 partial arm discarded", rd, 8'h00);
  endtask

  task automatic testWriteRead();
    logic [7:0] d, a, b, c;
    oneByte(8'h06);
    selLow(); sendAddr(8'h02, 16'h0100); xfer(8'h11, d); xfer(8'h22, d); xfer(8'h33, d); selHigh();
    pollReady("R8 write", 1);
    readStatus(rd);
    check("R10 status after write", rd, 8'h00);
    selLow(); sendAddr(8'h03, 16'h0100); xfer(8'h00, a); xfer(8'h00, b); xfer(8'h00, c); selHigh();
    check("R7 R8 read byte 0", a, 8'h11);
    check("R7 R8 read byte 1", b, 8'h22);
    check("R7 R8 read byte 2", c, 8'h33);
  endtask

  task automatic testPageWrap();
    logic [7:0] d, a, b;
    oneByte(8'h06);
    selLow(); sendAddr(8'h02, 16'h021E);
    xfer(8'hA0, d); xfer(8'hA1, d); xfer(8'hA2, d); xfer(8'hA3, d); selHigh();
    pollReady("R8 page wrap", 1);
    selLow(); sendAddr(8'h03, 16'h021E); xfer(8'h00, a); xfer(8'h00, b); selHigh();
    check("R8 page tail 0x21E", a, 8'hA0);
    check("R8 page tail 0x21F", b, 8'hA1);
    selLow(); sendAddr(8'h03, 16'h0200); xfer(8'h00, a); xfer(8'h00, b); selHigh();
    check("R8 wrapped to 0x200", a, 8'hA2);
    check("R8 wrapped to 0x201", b, 8'hA3);
  endtask

  task automatic testLastWins();
    logic [7:0] d, a, b;
    oneByte(8'h06);
    selLow(); sendAddr(8'h02, 16'h0300);
    for (int i = 0; i < 33; i++) xfer(8'h40 + 8'(i), d);
    selHigh();
    pollReady("R8 overwrite", 1);
    selLow(); sendAddr(8'h03, 16'h0300); xfer(8'h00, a); xfer(8'h00, b); selHigh();
    check("R8 later byte replaces offset 0", a, 8'h60);
    check("R8 offset 1 kept", b, 8'h41);
  endtask

  task automatic testArrayWrap();
    logic [7:0] d, a, b, c;
    oneByte(8'h06);
    selLow(); sendAddr(8'h02, 16'h07FE); xfer(8'h5A, d); xfer(8'h5B, d); selHigh();
    pollReady("R7 setup high", 1);
    oneByte(8'h06);
    selLow(); sendAddr(8'h02, 16'h0000); xfer(8'h6C, d); selHigh();
    pollReady("R7 setup low", 1);
    selLow(); sendAddr(8'h03, 16'hF7FE); xfer(8'h00, a); xfer(8'h00, b); xfer(8'h00, c); selHigh();
    check("R7 upper address ignored", a, 8'h5A);
    check("R7 last byte", b, 8'h5B);
    check("R7 wrap to address 0", c, 8'h6C);
  endtask

  task automatic testNoArm();
    logic [7:0] d;
    selLow(); sendAddr(8'h02, 16'h0100); xfer(8'hEE, d); selHigh();
    readStatus(rd);
    check("R12 unarmed write no busy", rd, 8'h00);
    readByteAt(16'h0100, rd);
    check("R12 unarmed write no store", rd, 8'h11);
    oneByte(8'h06);
    selLow(); sendAddr(8'h02, 16'h0100); selHigh();
    readStatus(rd);
    check("R12 write without data ignored", rd, 8'h02);
    selLow(); sendAddr(8'h02, 16'h0101); xfer(8'h99, d); sendBits(8'h55, 3); selHigh();
    readStatus(rd);
    check("R9 mid-byte write discarded", rd, 8'h02);
    oneByte(8'h04);
    readByteAt(16'h0101, rd);
    check("R9 mid-byte write no store", rd, 8'h22);
  endtask

  task automatic testStatusWrite();
    logic [7:0] d;
    oneByte(8'h06);
    selLow(); xfer(8'h01, d); xfer(8'hFF, d); selHigh();
    pollReady("R6 status write", 1);
    readStatus(rd);
    check("R6 only bits 7 3 2 written", rd, 8'h8C);
    selLow(); xfer(8'h01, d); xfer(8'h00, d); selHigh();
    readStatus(rd);
    check("R12 unarmed status write ignored", rd, 8'h8C);
    oneByte(8'h06);
    selLow(); xfer(8'h01, d); xfer(8'h70, d); xfer(8'hFF, d); selHigh();
    pollReady("R6 first byte used", 1);
    readStatus(rd);
    check("R6 bits 6:4 not writable, first byte used", rd, 8'h00);
  endtask

  task automatic testBusyIgnore();
    logic [7:0] d;
    oneByte(8'h06);
    selLow(); sendAddr(8'h02, 16'h0102); xfer(8'h77, d); selHigh();
    readByteAt(16'h0100, rd);
    check("R11 read ignored while busy", rd, 8'h00);
    pollReady("R11 status read accepted", 0);
    readByteAt(16'h0102, rd);
    check("R11 write landed after busy", rd, 8'h77);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(5);
    testReset();
    testOpcodes();
    testStatusRepeat();
    testMidByte();
    testWriteRead();
    testPageWrap();
    testLastWins();
    testArrayWrap();
    testNoArm();
    testStatusWrite();
    testBusyIgnore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule